// File: doc/BRIEF.md
# Word-Packing Serial Receiver with Idle Timeout

This block receives 8N1 asynchronous serial characters and groups them, four at a time, into 32-bit words. Each word goes into a small receive word queue, which the consumer drains through a show-ahead pop port. Characters are collected only while a receive transfer is armed. Software arms a transfer by presenting the number of characters it expects.

A transfer can close in two ways. The first is that the expected count is reached. The second is that, once at least one character has arrived, the line stays idle for a programmable number of character-times. Either way, a word that is only partly filled is pushed with its unused upper bytes at zero. The number of valid characters the transfer delivered is frozen in a snapshot output, and the block then ignores the line until the next arm.

Command pulses do the following:
- turn idle-timeout detection on and off;
- clear the pending timeout flag;
- clear the error flags;
- flush the receiver.

A four-bit interrupt-status output gives the status flags ANDed with a mask.

Top module: `rxw_top`

## Requirements
- R1: Characters are placed into words in arrival order, with the first character in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24. Data bits on the line arrive LSB first.
- R2: When an armed non-zero count is reached, the transfer ends and `xfer_done` is set. If the word is only partly filled, it is pushed with zero upper bytes.
- R3: When a transfer ends, `snap_count` holds the number of characters the transfer received. It keeps that value until the next end or a receiver flush.
- R4: With detection enabled, a transfer that has received at least one character ends after `stale_chars` character-times of idle line. One character-time is 10 bit periods. At that point any partial word is pushed zero-filled and `stale_pend` is set. A transfer with no characters never times out.
- R5: Timeout detection is off after reset. `stale_on` turns it on and `stale_off` turns it off. `stale_clr` clears `stale_pend`.
- R6: `word_ready` is high whenever the queue holds at least one word. `pop_data` then shows the oldest word, and a `pop` pulse removes it.
- R7: A word that must be pushed while the queue is full is lost and sets `overrun`. `err_clr` clears `overrun`.
- R8: A character whose stop bit samples low is still delivered, and it sets `frame_err`. `err_clr` clears `frame_err`.
- R9: A start bit is accepted only if the line is still low at its midpoint. A low pulse shorter than half a bit produces no character.
- R10: After a transfer ends, further characters change neither the queue nor the snapshot until the next arm. An armed count of zero sets no count limit, so only a timeout ends that transfer.
- R11: `rx_flush` empties the queue, discards any partial word, clears `xfer_done`, `stale_pend` and `snap_count`, and disarms the transfer.
- R12: `irq_status` is `{stale_pend, frame_err, overrun, word_ready} & irq_mask`, registered one cycle later.
- R13: After reset, `word_ready`, `overrun`, `frame_err`, `stale_pend`, `xfer_done`, `snap_count` and `irq_status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| arm_valid | input | 1 | Pulse: arm a new transfer |
| arm_count | input | CNT_W | Expected characters (0 = no limit) |
| stale_chars | input | STALE_W | Idle timeout in character-times |
| stale_on | input | 1 | Pulse: enable timeout detection |
| stale_off | input | 1 | Pulse: disable timeout detection |
| stale_clr | input | 1 | Pulse: clear pending timeout flag |
| err_clr | input | 1 | Pulse: clear overrun and framing flags |
| rx_flush | input | 1 | Pulse: flush queue and transfer state |
| irq_mask | input | 4 | Interrupt mask |
| pop | input | 1 | Remove the oldest word |
| pop_data | output | 32 | Oldest queued word |
| word_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Word lost to a full queue |
| frame_err | output | 1 | Stop bit sampled low |
| stale_pend | output | 1 | Transfer ended by idle timeout |
| xfer_done | output | 1 | Current transfer has ended |
| snap_count | output | CNT_W | Characters delivered by the last transfer |
| irq_status | output | 4 | Masked status |

## Verification
The bench builds the block with one clock per oversample tick, so one bit period is 16 cycles and one character-time is 160 cycles. This keeps a multi-character timeout wait to a few hundred cycles. The queue is built two words deep, so the third word of a twelve-character transfer already meets a full queue and the overrun path can be reached. The counter widths are cut to 8 and 4 bits, and the timeout is set to one or two character-times, so the bench can check both just before and just after the expiry point.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    SM_IDLE, SM_START, SM_DATA, SM_STOP, SM_HOLD
  } samp_state_t;

  localparam int IRQ_READY = 0;
  localparam int IRQ_OVR   = 1;
  localparam int IRQ_FRAME = 2;
  localparam int IRQ_STALE = 3;
endpackage

// File: rtl/rxw_sampler.sv
module rxw_sampler
  import rxw_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int OVS_DIV = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  output logic       os_tick,
  output logic       ch_valid,
  output logic [7:0] ch_data,
  output logic       ch_bad_stop,
  output logic       busy
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic rx_s1, rx_s2;
  samp_state_t st;
  logic [PH_W-1:0] ph;
  logic [2:0] bit_idx;
  logic [7:0] shreg;

  generate
    if (OVS_DIV == 1) begin : g_nodiv
      assign os_tick = 1'b1;
    end else begin : g_div
      localparam int DV_W = $clog2(OVS_DIV);
      logic [DV_W-1:0] dv;
      always_ff @(posedge clk) begin
        if (rst) dv <= '0;
        else if (dv == DV_W'(OVS_DIV - 1)) dv <= '0;
        else dv <= dv + 1'b1;
      end
      assign os_tick = (dv == DV_W'(OVS_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SM_IDLE; ph <= '0; bit_idx <= '0; shreg <= '0;
      ch_valid <= 1'b0; ch_data <= '0; ch_bad_stop <= 1'b0;
    end else begin
      ch_valid <= 1'b0;
      case (st)
        SM_IDLE: begin
          ph <= '0;
          if (!rx_s2) st <= SM_START;
        end
        SM_START: if (os_tick) begin
          if (rx_s2) st <= SM_IDLE;
          else if (ph == PH_MID) begin
            ph <= '0; bit_idx <= '0; st <= SM_DATA;
          end else ph <= ph + 1'b1;
        end
        SM_DATA: if (os_tick) begin
          if (ph == PH_LAST) begin
            ph <= '0;
            shreg <= {rx_s2, shreg[7:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) st <= SM_STOP;
          end else ph <= ph + 1'b1;
        end
        SM_STOP: if (os_tick) begin
          if (ph == PH_LAST) begin
            ch_valid    <= 1'b1;
            ch_data     <= shreg;
            ch_bad_stop <= !rx_s2;
            st          <= rx_s2 ? SM_IDLE : SM_HOLD;
          end else ph <= ph + 1'b1;
        end
        SM_HOLD: if (rx_s2) st <= SM_IDLE;
        default: st <= SM_IDLE;
      endcase
    end
  end

  assign busy = (st != SM_IDLE);

  AST_CHAR_SPACED: assert property (@(posedge clk) disable iff (rst)
    ch_valid |=> !ch_valid); // R9
endmodule

// File: rtl/rxw_fifo.sv
module rxw_fifo #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          not_empty,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wp, rp;
  logic full, empty;

  assign empty     = (wp == rp);
  assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign not_empty = !empty;
  assign overflow  = wr && full;
  assign rdata     = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr && !full) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0; rp <= '0;
    end else begin
      if (wr && !full) wp <= wp + 1'b1;
      if (rd && !empty) rp <= rp + 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (wp - rp) <= (AW+1)'(DEPTH)); // R7
endmodule

// File: rtl/rxw_xfer.sv
module rxw_xfer #(
  parameter int OVS     = 16,
  parameter int CNT_W   = 16,
  parameter int STALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               os_tick,
  input  logic               ch_valid,
  input  logic [7:0]         ch_data,
  input  logic               busy,
  input  logic               arm_valid,
  input  logic [CNT_W-1:0]   arm_count,
  input  logic [STALE_W-1:0] stale_chars,
  input  logic               stale_on,
  input  logic               stale_off,
  input  logic               stale_clr,
  input  logic               rx_flush,
  output logic               push,
  output logic [31:0]        push_word,
  output logic               done,
  output logic               stale_pend,
  output logic [CNT_W-1:0]   snap
);
  localparam int CHAR_TICKS = 10 * OVS;
  localparam int TK_W = $clog2(CHAR_TICKS);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active, stale_en;
  logic [CNT_W-1:0] target, rx_cnt;
  logic [1:0] idx;
  logic [31:0] pack, pack_n;
  logic [TK_W-1:0] tk;
  logic [STALE_W-1:0] ct;
  logic run, fire, last_by_cnt;

  always_comb begin
    pack_n = pack;
    pack_n[idx*8 +: 8] = ch_data;
  end

  assign last_by_cnt = (target != '0) && (rx_cnt + ONE == target);
  assign run  = active && stale_en && (rx_cnt != '0) && !busy && !ch_valid;
  assign fire = run && (ct != '0) && (ct >= stale_chars);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tk <= '0; ct <= '0;
    end else if (os_tick) begin
      if (tk == TK_W'(CHAR_TICKS - 1)) begin
        tk <= '0;
        if (ct != '1) ct <= ct + 1'b1;
      end else tk <= tk + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stale_en <= 1'b0;
    else if (stale_on) stale_en <= 1'b1;
    else if (stale_off) stale_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || rx_flush) begin
      active <= 1'b0; done <= 1'b0; stale_pend <= 1'b0; snap <= '0;
      target <= '0; rx_cnt <= '0; idx <= '0; pack <= '0;
      push <= 1'b0; push_word <= '0;
    end else begin
      push <= 1'b0;
      if (stale_clr) stale_pend <= 1'b0;
      if (arm_valid) begin
        active <= 1'b1; done <= 1'b0; target <= arm_count;
        rx_cnt <= '0; idx <= '0; pack <= '0;
      end else if (active && ch_valid) begin
        rx_cnt <= rx_cnt + ONE;
        if (idx == 2'd3 || last_by_cnt) begin
          push <= 1'b1; push_word <= pack_n; pack <= '0; idx <= '0;
        end else begin
          pack <= pack_n; idx <= idx + 1'b1;
        end
        if (last_by_cnt) begin
          active <= 1'b0; done <= 1'b1; snap <= rx_cnt + ONE;
        end
      end else if (fire) begin
        if (idx != 2'd0) begin
          push <= 1'b1; push_word <= pack;
        end
        pack <= '0; idx <= '0;
        active <= 1'b0; done <= 1'b1; stale_pend <= 1'b1; snap <= rx_cnt;
      end
    end
  end

  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (!active && !arm_valid) |=> !push); // R10
  AST_SNAP_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
    (active && ch_valid && !arm_valid && !rx_flush && last_by_cnt)
      |=> (done && snap == $past(target))); // R3
  AST_STALE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (rst)
    $rose(stale_pend) |-> ($past(rx_cnt) != '0)); // R4
endmodule

// File: rtl/rxw_top.sv
module rxw_top
  import rxw_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int OVS_DIV = 1,
  parameter int FIFO_AW = 3,
  parameter int CNT_W   = 16,
  parameter int STALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxd,
  input  logic               arm_valid,
  input  logic [CNT_W-1:0]   arm_count,
  input  logic [STALE_W-1:0] stale_chars,
  input  logic               stale_on,
  input  logic               stale_off,
  input  logic               stale_clr,
  input  logic               err_clr,
  input  logic               rx_flush,
  input  logic [3:0]         irq_mask,
  input  logic               pop,
  output logic [31:0]        pop_data,
  output logic               word_ready,
  output logic               overrun,
  output logic               frame_err,
  output logic               stale_pend,
  output logic               xfer_done,
  output logic [CNT_W-1:0]   snap_count,
  output logic [3:0]         irq_status
);
  logic os_tick, ch_valid, ch_bad_stop, busy, push, ovf;
  logic [7:0] ch_data;
  logic [31:0] push_word;
  logic [3:0] raw;

  rxw_sampler #(.OVS(OVS), .OVS_DIV(OVS_DIV)) u_samp (
    .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_bad_stop(ch_bad_stop), .busy(busy)
  );

  rxw_xfer #(.OVS(OVS), .CNT_W(CNT_W), .STALE_W(STALE_W)) u_xfer (
    .clk(clk), .rst(rst), .os_tick(os_tick), .ch_valid(ch_valid), .ch_data(ch_data),
    .busy(busy), .arm_valid(arm_valid), .arm_count(arm_count),
    .stale_chars(stale_chars), .stale_on(stale_on), .stale_off(stale_off),
    .stale_clr(stale_clr), .rx_flush(rx_flush), .push(push), .push_word(push_word),
    .done(xfer_done), .stale_pend(stale_pend), .snap(snap_count)
  );

  rxw_fifo #(.AW(FIFO_AW), .DW(32)) u_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush), .wr(push), .wdata(push_word),
    .rd(pop), .rdata(pop_data), .not_empty(word_ready), .overflow(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0; frame_err <= 1'b0;
    end else if (err_clr) begin
      overrun <= 1'b0; frame_err <= 1'b0;
    end else begin
      if (ovf) overrun <= 1'b1;
      if (ch_valid && ch_bad_stop) frame_err <= 1'b1;
    end
  end

  always_comb begin
    raw = '0;
    raw[IRQ_READY] = word_ready;
    raw[IRQ_OVR]   = overrun;
    raw[IRQ_FRAME] = frame_err;
    raw[IRQ_STALE] = stale_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_status <= '0;
    else irq_status <= raw & irq_mask;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_status & ~$past(irq_mask)) == 4'b0); // R12
  AST_OVR_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
    (ovf && !err_clr) |=> overrun); // R7
endmodule

// File: tb/tb_rxw_top.sv
module tb_rxw_top;
  localparam int BIT = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1, arm_valid = 0, stale_on = 0, stale_off = 0, stale_clr = 0;
  logic err_clr = 0, rx_flush = 0, pop = 0;
  logic [7:0] arm_count = '0;
  logic [3:0] stale_chars = 4'd2, irq_mask = '0;
  logic [31:0] pop_data;
  logic word_ready, overrun, frame_err, stale_pend, xfer_done;
  logic [7:0] snap_count;
  logic [3:0] irq_status;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  rxw_top #(.OVS(16), .OVS_DIV(1), .FIFO_AW(1), .CNT_W(8), .STALE_W(4)) dut (
    .clk(clk), .rst(rst), .rxd(rxd), .arm_valid(arm_valid), .arm_count(arm_count),
    .stale_chars(stale_chars), .stale_on(stale_on), .stale_off(stale_off),
    .stale_clr(stale_clr), .err_clr(err_clr), .rx_flush(rx_flush), .irq_mask(irq_mask),
    .pop(pop), .pop_data(pop_data), .word_ready(word_ready), .overrun(overrun),
    .frame_err(frame_err), .stale_pend(stale_pend), .xfer_done(xfer_done),
    .snap_count(snap_count), .irq_status(irq_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic arm(input logic [7:0] n);
    @(negedge clk); arm_count = n; arm_valid = 1'b1; @(negedge clk); arm_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop_v);
    @(negedge clk);
    rxd = 1'b0; wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_cyc(BIT); end
    rxd = stop_v; wait_cyc(BIT);
    rxd = 1'b1; wait_cyc(6);
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    chk(req, {31'b0, word_ready}, 32'h1);
    chk(req, pop_data, exp);
    @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0; wait_cyc(1);
  endtask

  task automatic fresh();
    pulse(rx_flush); pulse(err_clr); pulse(stale_clr); wait_cyc(2);
  endtask

  task automatic t_reset_state();
    chk("R13 ready", {31'b0, word_ready}, 0);
    chk("R13 flags", {28'b0, overrun, frame_err, stale_pend, xfer_done}, 0);
    chk("R13 snap", {24'b0, snap_count}, 0);
    chk("R13 irq", {28'b0, irq_status}, 0);
  endtask

  task automatic t_count_end();
    fresh(); pulse(stale_off); arm(8'd4);
    send_byte("A", 1); send_byte("B", 1); send_byte("C", 1); send_byte("D", 1);
    wait_cyc(4);
    chk("R2 done", {31'b0, xfer_done}, 1);
    chk("R3 snap", {24'b0, snap_count}, 4);
    pop_chk("R1 pack order", 32'h44434241);
    chk("R6 empty after pop", {31'b0, word_ready}, 0);
    send_byte("E", 1); wait_cyc(4);  // R10: ignored after end
    chk("R10 no word", {31'b0, word_ready}, 0);
    chk("R10 snap held", {24'b0, snap_count}, 4);
  endtask

  task automatic t_partial_count();
    fresh(); arm(8'd6);
    send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
    send_byte(8'h44, 1); send_byte(8'h45, 1); send_byte(8'h46, 1);
    wait_cyc(4);
    chk("R3 snap6", {24'b0, snap_count}, 6);
    pop_chk("R1 word0", 32'h44332211);
    pop_chk("R2 partial zero fill", 32'h00004645);
  endtask

  task automatic t_stale();
    fresh(); stale_chars = 4'd2; pulse(stale_on); arm(8'd10);
    send_byte(8'h78, 1); send_byte(8'h79, 1); send_byte(8'h7A, 1);
    wait_cyc(200);
    chk("R4 not yet", {31'b0, stale_pend}, 0);
    wait_cyc(200);
    chk("R4 pend", {31'b0, stale_pend}, 1);
    chk("R4 done", {31'b0, xfer_done}, 1);
    chk("R3 stale snap", {24'b0, snap_count}, 3);
    pop_chk("R4 flush zero fill", 32'h007A7978);
    pulse(stale_clr); wait_cyc(1);
    chk("R5 clr", {31'b0, stale_pend}, 0);
  endtask

  task automatic t_stale_gate();
    fresh(); pulse(stale_on); arm(8'd3); wait_cyc(500);
    chk("R4 no chars no timeout", {30'b0, stale_pend, xfer_done}, 0);
    pulse(stale_off); arm(8'd10);
    send_byte(8'h61, 1); send_byte(8'h62, 1); wait_cyc(500);
    chk("R5 disabled", {29'b0, stale_pend, xfer_done, word_ready}, 0);
    pulse(stale_on); wait_cyc(400);
    chk("R5 enabled fires", {31'b0, stale_pend}, 1);
    chk("R3 snap2", {24'b0, snap_count}, 2);
    pop_chk("R5 word", 32'h00006261);
  endtask

  task automatic t_unlimited();
    fresh(); stale_chars = 4'd1; pulse(stale_on); arm(8'd0);
    for (int i = 0; i < 5; i++) send_byte(8'h30 + 8'(i), 1);
    wait_cyc(4);
    chk("R10 count0 still open", {31'b0, xfer_done}, 0);
    wait_cyc(250);
    chk("R10 count0 stale end", {31'b0, xfer_done}, 1);
    chk("R3 snap5", {24'b0, snap_count}, 5);
    pop_chk("R10 w0", 32'h33323130);
    pop_chk("R10 w1", 32'h00000034);
    pulse(stale_off);
  endtask

  task automatic t_overrun();
    fresh(); arm(8'd12);
    for (int i = 0; i < 12; i++) send_byte(8'hA0 + 8'(i), 1);
    wait_cyc(4);
    chk("R7 overrun", {31'b0, overrun}, 1);
    pop_chk("R7 first kept", 32'hA3A2A1A0);
    pop_chk("R7 second kept", 32'hA7A6A5A4);
    chk("R7 third lost", {31'b0, word_ready}, 0);
    pulse(err_clr); wait_cyc(1);
    chk("R7 cleared", {31'b0, overrun}, 0);
  endtask

  task automatic t_frame_irq();
    fresh(); arm(8'd1);
    send_byte(8'h5A, 0); wait_cyc(4);
    chk("R8 frame err", {31'b0, frame_err}, 1);
    irq_mask = 4'b0100; wait_cyc(2);
    chk("R12 masked frame", {28'b0, irq_status}, 32'h4);
    irq_mask = 4'b1011; wait_cyc(2);
    chk("R12 ready only", {28'b0, irq_status}, 32'h1);
    irq_mask = 4'b0000;
    pop_chk("R8 delivered", 32'h0000005A);
    pulse(err_clr); wait_cyc(1);
    chk("R8 cleared", {31'b0, frame_err}, 0);
  endtask

  task automatic t_glitch();
    fresh(); arm(8'd1);
    @(negedge clk); rxd = 1'b0; wait_cyc(4); rxd = 1'b1; wait_cyc(300);
    chk("R9 glitch ignored", {30'b0, xfer_done, word_ready}, 0);
    send_byte(8'h51, 1); wait_cyc(4);
    pop_chk("R9 real char", 32'h00000051);
  endtask

  task automatic t_flush();
    fresh(); arm(8'd8);
    for (int i = 0; i < 5; i++) send_byte(8'hC0 + 8'(i), 1);
    wait_cyc(4);
    chk("R11 word queued", {31'b0, word_ready}, 1);
    pulse(rx_flush); wait_cyc(1);
    chk("R11 flushed", {31'b0, word_ready}, 0);
    chk("R11 snap clr", {24'b0, snap_count}, 0);
    arm(8'd2); send_byte(8'h5A, 1); send_byte(8'h59, 1); wait_cyc(4);
    pop_chk("R11 partial discarded", 32'h0000595A);
  endtask

  initial begin
    wait_cyc(5); rst = 1'b0; wait_cyc(2);
    t_reset_state();
    t_count_end();
    t_partial_count();
    t_stale();
    t_stale_gate();
    t_unlimited();
    t_overrun();
    t_frame_irq();
    t_glitch();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule